// File: doc/BRIEF.md
# Banked Cascaded Interrupt Controller

This block gathers a large set of level-sensitive interrupt request lines, arranged as equal-width banks, and presents them to a processor as two request outputs plus a ready-decoded vector. Each line is captured through one flop into a per-bank status register. Two separate enable registers per bank decide which pending sources reach each of the two request outputs. One request output, the primary one, also drives a combinational priority encoder. The encoder reports the number of the most urgent pending source, so the interrupt handler does not have to scan the banks in software.

A group of software-settable interrupt bits, with its own enable register, is folded into a single status bit of bank 0. When that folded bit is pending under the primary enable set, the encoder reports the lowest pending software bit ahead of every other source. Interrupts from an external GPIO unit need no special treatment: the GPIO unit's combined level is wired to an ordinary line of bank 1. All registers sit on a simple register bus with a write strobe, an address, write data and combinational read data.

Top module: `irqc_cascade_top`

## Requirements
- R1: After reset every enable register, the software interrupt bits and the software enable register read as zero, and both request outputs are low.
- R2: Each status bit reads as the level of its line one clock earlier. The bank-0 bit at position SW_CASC_BIT (default 4) is the exception: it reads as the OR of the software bits ANDed with the software enables, with no delay, and the line at that position is ignored. Status registers sit at address 0 + bank.
- R3: A source is pending only when its status bit and its primary enable bit are both 1. irq_out_a is high exactly when at least one source is pending under the primary enables (address 4 + bank).
- R4: irq_out_b is high exactly when any status bit is set together with its bit in the secondary enable set (address 8 + bank), independently of the primary set.
- R5: With no software vector active, vec_code = bank*32 + bit of the pending source in the lowest-numbered bank that has one, taking the lowest bit index within that bank.
- R6: When the bank-0 cascade bit is pending under the primary enables, vec_code = 96 + the lowest index among the software bits that are both set and enabled, even if other bank-0 bits are pending.
- R7: The software bits (address 12) and software enables (address 13) take the full write data, so a write both sets and clears bits. All enable and software registers read back what was last written. Writes to status addresses change nothing, and unmapped addresses read as zero.
- R8: vec_valid equals irq_out_a, and vec_code is 0 whenever vec_valid is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_lines | input | 96 | Level request lines, bank b on bits [32b+31:32b] |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 4 | Register address: group in [3:2], bank or index in [1:0] |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data for bus_addr (combinational) |
| irq_out_a | output | 1 | Request output under the primary enable set |
| irq_out_b | output | 1 | Request output under the secondary enable set |
| vec_valid | output | 1 | A source is pending under the primary enable set |
| vec_code | output | 7 | Number of the highest-priority pending source |

## Verification
The hardest situation to reach from the ports is a software vector that overrides a lower-numbered hardware bit in bank 0. It needs a software bit that is set, its software enable, the primary enable of the cascade bit, and a competing bank-0 line all at once. Random register writes reach this only rarely, so a directed sequence builds it step by step and then removes the software enable to watch the vector fall back to the hardware source. The random phase keeps the lines sparse and often leaves whole banks empty, so the lower-priority banks 1 and 2 still win the encoder often enough.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
   // register group, decoded from bus_addr[3:2]
   typedef enum logic [1:0] {
      GRP_STAT = 2'd0,
      GRP_ENA  = 2'd1,
      GRP_ENB  = 2'd2,
      GRP_SW   = 2'd3
   } irqc_grp_e;

   localparam logic [1:0] SW_IDX_BITS = 2'd0;
   localparam logic [1:0] SW_IDX_EN   = 2'd1;
endpackage

// File: rtl/irqc_lowest.sv
// Finds the lowest set bit of a request vector.
module irqc_lowest #(
   parameter int W  = 32,
   localparam int IW = (W > 1) ? $clog2(W) : 1
) (
   input  logic [W-1:0]  req,
   output logic          found,
   output logic [IW-1:0] idx
);
   always_comb begin
      found = |req;
      idx   = '0;
      for (int i = W - 1; i >= 0; i--) begin
         if (req[i]) idx = IW'(i);
      end
   end
endmodule

// File: rtl/irqc_bank.sv
// One bank: registered status, two enable sets, pending vectors.
module irqc_bank #(
   parameter int W        = 32,
   parameter bit HAS_CASC = 1'b0,
   parameter int CASC_BIT = 0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] lines,
   input  logic         casc_in,
   input  logic         wr_ena,
   input  logic         wr_enb,
   input  logic [W-1:0] wdata,
   output logic [W-1:0] status,
   output logic [W-1:0] ena,
   output logic [W-1:0] enb,
   output logic [W-1:0] pend_a,
   output logic [W-1:0] pend_b
);
   localparam logic [W-1:0] CASC_MASK = HAS_CASC ? (W'(1) << CASC_BIT) : '0;

   logic [W-1:0] raw_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         raw_q <= '0;
         ena   <= '0;
         enb   <= '0;
      end else begin
         raw_q <= lines & ~CASC_MASK;
         if (wr_ena) ena <= wdata;
         if (wr_enb) enb <= wdata;
      end
   end

   always_comb begin
      status = raw_q | (CASC_MASK & {W{casc_in}});
      pend_a = status & ena;
      pend_b = status & enb;
   end
endmodule

// File: rtl/irqc_swgroup.sv
// Software interrupt bits with their own enables, folded into one cascade bit.
module irqc_swgroup #(
   parameter int W  = 32,
   localparam int IW = (W > 1) ? $clog2(W) : 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_bits,
   input  logic          wr_en,
   input  logic [W-1:0]  wdata,
   output logic [W-1:0]  sw_bits,
   output logic [W-1:0]  sw_en,
   output logic          casc,
   output logic [IW-1:0] sw_idx
);
   logic [W-1:0] sw_pend;
   logic         sw_found;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sw_bits <= '0;
         sw_en   <= '0;
      end else begin
         if (wr_bits) sw_bits <= wdata;
         if (wr_en)   sw_en   <= wdata;
      end
   end

   assign sw_pend = sw_bits & sw_en;

   irqc_lowest #(.W(W)) i_sw_enc (
      .req   (sw_pend),
      .found (sw_found),
      .idx   (sw_idx)
   );

   assign casc = sw_found;
endmodule

// File: rtl/irqc_cascade_top.sv
module irqc_cascade_top #(
   parameter int BANK_W      = 32,
   parameter int NUM_BANKS   = 3,
   parameter int SW_BANK     = 0,
   parameter int SW_CASC_BIT = 4,
   localparam int NSRC  = NUM_BANKS * BANK_W,
   localparam int VEC_W = $clog2(NSRC + BANK_W)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NSRC-1:0]   irq_lines,
   input  logic              bus_wr,
   input  logic [3:0]        bus_addr,
   input  logic [BANK_W-1:0] bus_wdata,
   output logic [BANK_W-1:0] bus_rdata,
   output logic              irq_out_a,
   output logic              irq_out_b,
   output logic              vec_valid,
   output logic [VEC_W-1:0]  vec_code
);
   import irqc_pkg::*;

   localparam int IW = (BANK_W > 1) ? $clog2(BANK_W) : 1;

   // elaboration-time parameter checks
   if (NUM_BANKS < 1 || NUM_BANKS > 4) begin : g_chk_banks
      $error("irqc_cascade_top: NUM_BANKS must be 1..4");
   end
   if (SW_BANK < 0 || SW_BANK >= NUM_BANKS) begin : g_chk_swbank
      $error("irqc_cascade_top: SW_BANK out of range");
   end
   if (SW_CASC_BIT < 0 || SW_CASC_BIT >= BANK_W) begin : g_chk_swbit
      $error("irqc_cascade_top: SW_CASC_BIT out of range");
   end

   irqc_grp_e   grp;
   logic [1:0]  idx;
   assign grp = irqc_grp_e'(bus_addr[3:2]);
   assign idx = bus_addr[1:0];

   logic [BANK_W-1:0] stat  [NUM_BANKS];
   logic [BANK_W-1:0] ena_r [NUM_BANKS];
   logic [BANK_W-1:0] enb_r [NUM_BANKS];
   logic [BANK_W-1:0] pa    [NUM_BANKS];
   logic [BANK_W-1:0] pb    [NUM_BANKS];
   logic [IW-1:0]     bk_idx[NUM_BANKS];
   logic [NUM_BANKS-1:0] bk_found;

   logic [BANK_W-1:0] sw_bits, sw_en;
   logic              sw_casc;
   logic [IW-1:0]     sw_idx;

   irqc_swgroup #(.W(BANK_W)) i_swgroup (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_bits (bus_wr && grp == GRP_SW && idx == SW_IDX_BITS),
      .wr_en   (bus_wr && grp == GRP_SW && idx == SW_IDX_EN),
      .wdata   (bus_wdata),
      .sw_bits (sw_bits),
      .sw_en   (sw_en),
      .casc    (sw_casc),
      .sw_idx  (sw_idx)
   );

   for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
      irqc_bank #(
         .W        (BANK_W),
         .HAS_CASC (b == SW_BANK),
         .CASC_BIT (SW_CASC_BIT)
      ) i_bank (
         .clk     (clk),
         .rst_n   (rst_n),
         .lines   (irq_lines[b*BANK_W +: BANK_W]),
         .casc_in (sw_casc),
         .wr_ena  (bus_wr && grp == GRP_ENA && idx == 2'(b)),
         .wr_enb  (bus_wr && grp == GRP_ENB && idx == 2'(b)),
         .wdata   (bus_wdata),
         .status  (stat[b]),
         .ena     (ena_r[b]),
         .enb     (enb_r[b]),
         .pend_a  (pa[b]),
         .pend_b  (pb[b])
      );

      irqc_lowest #(.W(BANK_W)) i_enc (
         .req   (pa[b]),
         .found (bk_found[b]),
         .idx   (bk_idx[b])
      );
   end

   // request outputs
   always_comb begin
      irq_out_a = 1'b0;
      irq_out_b = 1'b0;
      for (int b = 0; b < NUM_BANKS; b++) begin
         irq_out_a = irq_out_a | (|pa[b]);
         irq_out_b = irq_out_b | (|pb[b]);
      end
   end

   // vector: software group first, then banks from lowest number
   logic sw_route;
   assign sw_route = pa[SW_BANK][SW_CASC_BIT];

   always_comb begin
      vec_valid = 1'b0;
      vec_code  = '0;
      for (int b = NUM_BANKS - 1; b >= 0; b--) begin
         if (bk_found[b]) begin
            vec_valid = 1'b1;
            vec_code  = VEC_W'(b * BANK_W) + VEC_W'(bk_idx[b]);
         end
      end
      if (sw_route) begin
         vec_valid = 1'b1;
         vec_code  = VEC_W'(NSRC) + VEC_W'(sw_idx);
      end
   end

   // register read mux
   always_comb begin
      bus_rdata = '0;
      case (grp)
         GRP_STAT: for (int b = 0; b < NUM_BANKS; b++) if (idx == 2'(b)) bus_rdata = stat[b];
         GRP_ENA:  for (int b = 0; b < NUM_BANKS; b++) if (idx == 2'(b)) bus_rdata = ena_r[b];
         GRP_ENB:  for (int b = 0; b < NUM_BANKS; b++) if (idx == 2'(b)) bus_rdata = enb_r[b];
         GRP_SW: begin
            if (idx == SW_IDX_BITS)    bus_rdata = sw_bits;
            else if (idx == SW_IDX_EN) bus_rdata = sw_en;
         end
         default: bus_rdata = '0;
      endcase
   end
endmodule

// File: rtl/irqc_checker.sv
module irqc_checker #(
   parameter int BANK_W      = 32,
   parameter int NUM_BANKS   = 3,
   parameter int SW_CASC_BIT = 4,
   localparam int NSRC  = NUM_BANKS * BANK_W,
   localparam int VEC_W = $clog2(NSRC + BANK_W),
   localparam int IW    = (BANK_W > 1) ? $clog2(BANK_W) : 1
) (
   input logic              clk,
   input logic              rst_n,
   input logic [NSRC-1:0]   irq_lines,
   input logic [3:0]        bus_addr,
   input logic [BANK_W-1:0] bus_rdata,
   input logic              irq_out_a,
   input logic              irq_out_b,
   input logic              vec_valid,
   input logic [VEC_W-1:0]  vec_code
);
   localparam logic [BANK_W-1:0] SWMASK = BANK_W'(1) << SW_CASC_BIT;

   AST_QUIET_AFTER_RESET: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(rst_n) |-> (!irq_out_a && !irq_out_b)); // R1

   AST_STATUS_BANK0: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && bus_addr == 4'h0) |->
      ((bus_rdata & ~SWMASK) == ($past(irq_lines[BANK_W-1:0]) & ~SWMASK))); // R2

   AST_STATUS_BANK_LAST: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && bus_addr == 4'(NUM_BANKS - 1)) |->
      (bus_rdata == $past(irq_lines[NSRC-1 -: BANK_W]))); // R2

   AST_VALID_IS_OUT_A: assert property (@(posedge clk) disable iff (!rst_n)
      vec_valid == irq_out_a); // R8

   AST_IDLE_VECTOR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      !vec_valid |-> vec_code == '0); // R8

   AST_SW_NEEDS_BITS: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_addr == 4'hC && bus_rdata == '0) |-> !(vec_valid && vec_code >= VEC_W'(NSRC))); // R6

   AST_BANK0_BIT_SET: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_addr == 4'h0 && vec_valid && vec_code < VEC_W'(BANK_W)) |->
      bus_rdata[vec_code[IW-1:0]]); // R5
endmodule

bind irqc_cascade_top irqc_checker #(
   .BANK_W      (BANK_W),
   .NUM_BANKS   (NUM_BANKS),
   .SW_CASC_BIT (SW_CASC_BIT)
) i_irqc_checker (
   .clk       (clk),
   .rst_n     (rst_n),
   .irq_lines (irq_lines),
   .bus_addr  (bus_addr),
   .bus_rdata (bus_rdata),
   .irq_out_a (irq_out_a),
   .irq_out_b (irq_out_b),
   .vec_valid (vec_valid),
   .vec_code  (vec_code)
);

// File: tb/test_irqc_cascade_top.sv
`timescale 1ns/1ps
module test_irqc_cascade_top;
   localparam int SWB = 4;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [95:0] irq_lines = '0;
   logic        bus_wr = 1'b0;
   logic [3:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        irq_out_a, irq_out_b, vec_valid;
   logic [6:0]  vec_code;

   int checks = 0;
   int fails  = 0;

   // model state
   logic [31:0] m_raw [3];
   logic [31:0] m_ena [3];
   logic [31:0] m_enb [3];
   logic [31:0] m_sw, m_swen;

   always #5 clk = ~clk;

   irqc_cascade_top i_irqc_cascade_top (
      .clk(clk), .rst_n(rst_n), .irq_lines(irq_lines),
      .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
      .bus_rdata(bus_rdata), .irq_out_a(irq_out_a), .irq_out_b(irq_out_b),
      .vec_valid(vec_valid), .vec_code(vec_code)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
      end
   endtask

   function automatic logic [31:0] m_status(input int b);
      logic [31:0] s;
      s = m_raw[b];
      if (b == 0) begin
         s[SWB] = |(m_sw & m_swen);
      end
      return s;
   endfunction

   function automatic logic [31:0] m_read(input logic [3:0] a);
      logic [1:0] g, i;
      g = a[3:2];
      i = a[1:0];
      if (g == 2'd3) return (i == 0) ? m_sw : (i == 1) ? m_swen : 32'h0;
      if (i == 2'd3) return 32'h0;
      if (g == 2'd0) return m_status(int'(i));
      if (g == 2'd1) return m_ena[i];
      return m_enb[i];
   endfunction

   function automatic int lowest(input logic [31:0] v);
      for (int i = 0; i < 32; i++) if (v[i]) return i;
      return -1;
   endfunction

   function automatic logic [7:0] m_vec();
      // returns {valid, code}
      if (m_status(0)[SWB] && m_ena[0][SWB])
         return {1'b1, 7'(96 + lowest(m_sw & m_swen))};
      for (int b = 0; b < 3; b++) begin
         if ((m_status(b) & m_ena[b]) != 0)
            return {1'b1, 7'(b * 32 + lowest(m_status(b) & m_ena[b]))};
      end
      return 8'h0;
   endfunction

   task automatic check_all();
      logic [7:0] ev;
      logic       ea, eb;
      ev = m_vec();
      ea = 1'b0;
      eb = 1'b0;
      for (int b = 0; b < 3; b++) begin
         ea = ea | (|(m_status(b) & m_ena[b]));
         eb = eb | (|(m_status(b) & m_enb[b]));
      end
      chk("R3", 32'(irq_out_a), 32'(ea));
      chk("R4", 32'(irq_out_b), 32'(eb));
      chk("R8", 32'(vec_valid), 32'(ev[7]));
      if (!ev[7])            chk("R8", 32'(vec_code), 32'h0);
      else if (ev[6:0] >= 96) chk("R6", 32'(vec_code), 32'(ev[6:0]));
      else                   chk("R5", 32'(vec_code), 32'(ev[6:0]));
      if (bus_addr[3:2] == 2'd0) chk("R2", bus_rdata, m_read(bus_addr));
      else                       chk("R7", bus_rdata, m_read(bus_addr));
   endtask

   task automatic tick();
      @(posedge clk);
      if (!rst_n) begin
         for (int b = 0; b < 3; b++) begin
            m_raw[b] = '0; m_ena[b] = '0; m_enb[b] = '0;
         end
         m_sw = '0; m_swen = '0;
      end else begin
         for (int b = 0; b < 3; b++) m_raw[b] = irq_lines[b*32 +: 32] & ~((b == 0) ? (32'h1 << SWB) : 32'h0);
         if (bus_wr) begin
            case (bus_addr[3:2])
               2'd1: if (bus_addr[1:0] != 2'd3) m_ena[bus_addr[1:0]] = bus_wdata;
               2'd2: if (bus_addr[1:0] != 2'd3) m_enb[bus_addr[1:0]] = bus_wdata;
               2'd3: begin
                  if (bus_addr[1:0] == 2'd0) m_sw = bus_wdata;
                  if (bus_addr[1:0] == 2'd1) m_swen = bus_wdata;
               end
               default: ;
            endcase
         end
      end
      @(negedge clk);
      if (rst_n) check_all();
   endtask

   task automatic wr(input logic [3:0] a, input logic [31:0] d);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      tick();
      bus_wr = 1'b0;
   endtask

   task automatic clear_all();
      for (int b = 0; b < 3; b++) begin
         wr(4'(4 + b), 32'h0);
         wr(4'(8 + b), 32'h0);
      end
      wr(4'hC, 32'h0);
      wr(4'hD, 32'h0);
      irq_lines = '0;
      tick();
   endtask

   initial begin
      #1_900_000;
      fails++;
      $display("FAIL watchdog: all requirements, actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      void'($urandom(32'd20240611));
      irq_lines = {3{32'hFFFF_FFFF}};
      repeat (3) tick();
      @(negedge clk);
      rst_n = 1'b1;
      irq_lines = '0;
      // R1: reset values of enables and software registers, quiet outputs
      for (int a = 4; a < 14; a++) begin
         bus_addr = 4'(a);
         #1;
         chk("R1", bus_rdata, 32'h0);
      end
      chk("R1", 32'({irq_out_a, irq_out_b}), 32'h0);
      tick();

      // R6: software vector beats bank-0 bit 0
      wr(4'h4, 32'hFFFF_FFFF);
      irq_lines = 96'h1;
      tick();
      chk("R5", 32'(vec_code), 32'd0);
      wr(4'hD, 32'h0000_0080);
      wr(4'hC, 32'h0000_00C0);
      chk("R6", 32'(vec_code), 32'd103);
      wr(4'hD, 32'h0);
      chk("R6", 32'(vec_code), 32'd0);
      // R7: writing zeros clears software bits
      wr(4'hC, 32'h0);
      bus_addr = 4'hC; #1;
      chk("R7", bus_rdata, 32'h0);

      // R5: bank 1 beats bank 2, bank 2 alone
      wr(4'h5, 32'hFFFF_FFFF);
      wr(4'h6, 32'hFFFF_FFFF);
      irq_lines = '0;
      irq_lines[35] = 1'b1;
      irq_lines[64] = 1'b1;
      tick();
      chk("R5", 32'(vec_code), 32'd35);
      irq_lines[35] = 1'b0;
      tick();
      chk("R5", 32'(vec_code), 32'd64);

      // R2: line at the software cascade position is ignored
      clear_all();
      wr(4'h4, 32'h1 << SWB);
      irq_lines[SWB] = 1'b1;
      bus_addr = 4'h0;
      tick();
      chk("R2", bus_rdata, 32'h0);
      chk("R3", 32'(irq_out_a), 32'h0);

      // R4: secondary set alone drives irq_out_b only
      irq_lines = '0;
      irq_lines[70] = 1'b1;
      wr(4'hA, 32'h0000_0040);
      chk("R4", 32'({irq_out_a, irq_out_b}), 32'h1);

      // R7: status writes change nothing
      wr(4'h2, 32'hFFFF_FFFF);
      bus_addr = 4'h2; #1;
      chk("R7", bus_rdata, 32'h0000_0040);
      bus_addr = 4'h7; #1;
      chk("R7", bus_rdata, 32'h0);
      clear_all();

      // random phase
      for (int n = 0; n < 4000; n++) begin
         bus_wr   = ($urandom % 4) == 0;
         bus_addr = 4'($urandom);
         bus_wdata = ($urandom % 2) ? ($urandom & $urandom) : ($urandom & $urandom & $urandom);
         if ($urandom % 3 == 0) begin
            for (int b = 0; b < 3; b++)
               irq_lines[b*32 +: 32] = ($urandom % 3 == 0) ? 32'h0 : ($urandom & $urandom & $urandom & $urandom);
         end
         tick();
      end
      bus_wr = 1'b0;

      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule